// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for a single read or write burst in a synchronous DRAM whose pages are 512 columns wide. A controller pulses `start` with a start column, a burst-length code and an ordering select. From the following cycle the block presents one column address per clock with `col_valid` high. `last_beat` marks the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column. They follow either a linear wrap-around order or an XOR-interleaved order. A full-page burst steps linearly through the whole page, wraps from the top column to column 0, and keeps going until `stop` ends it. A new `start` may replace a running burst on any cycle.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `col_valid` and `last_beat` are both 0.
- R2: `len_code` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Any value with bit 2 set selects full page. Beat 0 appears in the cycle after `start` is sampled, with `col` equal to `start_col`, and one beat follows per clock.
- R3: In linear order with burst length BL, beat k carries the start column with its low log2(BL) bits replaced by (start + k) mod BL. The upper bits stay unchanged.
- R4: In interleaved order (`interleave`=1, burst length 1 to 8), beat k carries the start column with its low log2(BL) bits XORed with k.
- R5: A full-page burst advances by one column per beat, wraps from 511 to 0, and runs until stopped. The `interleave` input has no effect on a full-page burst.
- R6: `last_beat` is high exactly on beat BL-1 of a fixed-length burst and never during a full-page burst. `col_valid` falls in the cycle after the last beat unless a new start arrives.
- R7: When `stop` is sampled high without `start`, `col_valid` is 0 in the following cycle.
- R8: When `start` is sampled during a burst, the running burst is abandoned and beat 0 of the new burst appears in the next cycle. `start` takes priority over `stop` in the same cycle.
- R9: Length and ordering are captured at start. Changes to `len_code` or `interleave` during a burst leave its sequence and its length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst at `start_col` |
| stop | input | 1 | Terminate the running burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, bit 2 set: full page) |
| interleave | input | 1 | 1 selects XOR-interleaved order |
| col | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| last_beat | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
Every start column in the page is swept against every fixed length in both orders, so the bench covers all wrap points inside an aligned block. A design that carried the increment into the upper bits, or that added k instead of XORing it, would leave the block or scramble the order on exactly those starts. Full-page runs begin just below the top of the page and continue past column 0 with interleave requested. This exposes a design that stalls at 511, raises `last_beat`, or switches to XOR order. Restarts mid-burst, `start` arriving together with `stop`, and configuration inputs that change during a burst show whether the block drops the new burst or takes the changed settings.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             last_beat
);

  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             act_q, il_q, full_q;
  logic [COL_W-1:0] mask_d, lin_col, il_col;
  logic             at_end;

  always_comb begin
    if (len_code[2]) mask_d = '1;
    else             mask_d = COL_W'((1 << len_code[1:0]) - 1);
  end

  assign at_end = !full_q && (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      il_q   <= 1'b0;
      full_q <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      base_q <= start_col;
      beat_q <= '0;
      mask_q <= mask_d;
      full_q <= len_code[2];
      il_q   <= interleave & ~len_code[2];
    end else if (act_q) begin
      if (stop || at_end) act_q <= 1'b0;
      else                beat_q <= beat_q + 1'b1;
    end
  end

  assign lin_col   = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
  assign il_col    = base_q ^ beat_q;
  assign col       = il_q ? il_col : lin_col;
  assign col_valid = act_q;
  assign last_beat = act_q && at_end;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !col_valid && !last_beat);

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && (col == $past(start_col)));

  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !il_q && !start && !stop && !last_beat) |=>
      ((col & ~mask_q) == ($past(col) & ~mask_q)));

  p_il_in_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !start && !stop && !last_beat) |=>
      col_valid && ((col ^ $past(col)) & ~mask_q) == '0);

  p_full_no_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && full_q) |-> !last_beat);

  p_last_is_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);

  p_end_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !col_valid);

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !col_valid);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && stop) |=> col_valid);

endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n, start, stop, interleave;
  logic [8:0] start_col;
  logic [2:0] len_code;
  logic [8:0] col;
  logic       col_valid, last_beat;
  int nvec = 0, nfail = 0;

  always #2.5 clk = ~clk;

  burst_col_gen #(.COL_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .start_col(start_col), .len_code(len_code), .interleave(interleave),
    .col(col), .col_valid(col_valid), .last_beat(last_beat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(input int b, input int bl, input bit il, input int k);
    int m = bl - 1;
    if (il) return b ^ k;
    return (b & ~m & 511) | ((b + k) & m);
  endfunction

  // drives start at a negedge; returns one cycle later with beat 0 visible
  task automatic kick(input int b, input int code, input bit il, input bit stp);
    start_col = 9'(b); len_code = 3'(code); interleave = il; start = 1'b1; stop = stp;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
  endtask

  task automatic run_fixed(input int b, input int code, input bit il, input bit scramble);
    int bl = 1 << code;
    kick(b, code, il, 1'b0);
    if (scramble) begin len_code = 3'd7; interleave = ~il; end
    for (int k = 0; k < bl; k++) begin
      chk("R2 valid", col_valid, 1);
      chk(il ? "R4 col" : "R3 col", col, exp_col(b, bl, il, k));
      chk("R6 last", last_beat, k == bl - 1);
      @(negedge clk);
    end
    chk(scramble ? "R9 end" : "R6 end", col_valid, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; start_col = '0; len_code = '0; interleave = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid", col_valid, 0);
    chk("R1 last", last_beat, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after", col_valid, 0);

    for (int c = 0; c < 4; c++)
      for (int il = 0; il < 2; il++)
        for (int b = 0; b < 512; b++)
          run_fixed(b, c, il[0], 1'b0);

    // R9: configuration changes mid-burst
    run_fixed(13, 3, 1'b1, 1'b1);
    run_fixed(6, 2, 1'b0, 1'b1);

    // R5: full page wrap, interleave ignored, no last
    for (int code = 4; code < 8; code += 3) begin
      kick(505, code, 1'b1, 1'b0);
      for (int k = 0; k < 530; k++) begin
        chk("R5 valid", col_valid, 1);
        chk("R5 col", col, (505 + k) % 512);
        chk("R5 last", last_beat, 0);
        @(negedge clk);
      end
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R7 full stop", col_valid, 0);
    end

    // R7: stop mid fixed burst
    kick(40, 3, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R7 pre", col, 42);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R7 stopped", col_valid, 0);
    @(negedge clk);
    chk("R7 stays", col_valid, 0);

    // R8: restart mid-burst, start beats stop
    kick(5, 3, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    kick(100, 2, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      chk("R8 valid", col_valid, 1);
      chk("R8 col", col, 100 ^ k);
      chk("R8 last", last_beat, k == 3);
      @(negedge clk);
    end
    chk("R8 end", col_valid, 0);

    // R8: restart on last beat
    kick(9, 1, 1'b0, 1'b0);
    chk("R8 lastbeat pre", last_beat, 0);
    @(negedge clk);
    chk("R8 lastbeat", last_beat, 1);
    kick(300, 0, 1'b0, 1'b0);
    chk("R8 back2back col", col, 300);
    chk("R8 back2back last", last_beat, 1);
    @(negedge clk);
    chk("R6 single end", col_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule